// File: doc/BRIEF.md
# Key-Locked Watchdog Reset Timer

This block is a watchdog that ends in a system reset pulse. Software reaches it through a small register port: a write strobe, a byte address and 16-bit write data, with read data returned combinationally for the address presented. Every configuration register is guarded by a lock. Only a write of the exact 16-bit key to the lock register opens the block, and any other value written there closes it again. The timeout is 32 bits wide and is programmed as two 16-bit halves. A slow time base, usually a 32.768 kHz clock brought into the system clock domain, reaches the block as a one-cycle `tick` strobe. One such tick per decrement means a 50 ms timeout is a low half of 1638 and a high half of 0.

The usual sequence is as follows. Software unlocks the block, optionally sets the mode-select bit, writes the high half and then the low half, sets run and reset-enable in one write, and finally relocks. A zero-to-one change of the run bit loads the counter from the combined value. The counter state machine has four states. `ST_IDLE` waits for run to be set (transition *arm*, to `ST_COUNT`). `ST_COUNT` counts ticks down. It leaves for `ST_IDLE` when run is cleared (*abort*). At expiry it goes to `ST_PULSE` if reset-enable is set (*fire*), or to `ST_HALT` if it is not (*expire_quiet*). `ST_PULSE` drives the reset output for a fixed number of system clocks and then moves to `ST_HALT` (*pulse_done*). `ST_HALT` holds until run is cleared (*release*, back to `ST_IDLE`).

Top module: `keyed_wdt`

## Requirements
- R1: After reset the lock register at offset 0x20 reads 1 (locked). The load halves and the control register read 0, and `wdt_reset` is low.
- R2: A write to offset 0x20 is always accepted. The value 0xE551 unlocks the block, so the lock register then reads 0. Any other value locks it, so it reads 1.
- R3: While the block is locked, writes to offsets 0x0, 0x4 and 0x8 change nothing. The registers read back unchanged, and a run bit written while locked starts no count.
- R4: Offset 0x0 holds the low 16 bits and offset 0x4 the high 16 bits of the timeout. Both read back what was written while unlocked, and the count uses {high, low}.
- R5: In the control register at offset 0x8, bit 1 is run, bit 2 is mode select and bit 3 is reset-enable. All other bits read 0. Mode select is stored and read back but does not change the count.
- R6: A 0-to-1 write of run loads the counter. Expiry happens at the clock edge that samples the N-th `tick` after that, for a timeout N ≥ 1. A timeout of 0 expires on the first tick.
- R7: On expiry with reset-enable set, `wdt_reset` rises in the cycle after the expiring edge and stays high for exactly 8 system clock cycles.
- R8: After expiry the counter stops. Further ticks give no new pulse until run has been cleared and set again.
- R9: On expiry with reset-enable clear, no pulse is produced and the counter stops.
- R10: Clearing run while counting stops the counter, and no pulse follows from later ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| tick | input | 1 | One-cycle strobe from the slow time base |
| wdt_reset | output | 1 | System reset pulse on expiry |

## Verification
The bench builds the block with its default parameters: a 16-bit half width, the 0xE551 key and an 8-cycle pulse. With these it checks the exact pulse length and the documented key. Timeouts of 0 to 3 ticks reach the tick-by-tick expiry edge, the zero-load case and the halt behaviour quickly. A load of high half 1 and low half 0, driven with a tick every cycle, reaches 65536 ticks. This shows that the high half really feeds the upper counter bits and that a carry across the halves is counted.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int ADDR_W = 6;

    // register offsets; software sequences rely on these
    localparam logic [ADDR_W-1:0] OFS_LOAD_LO = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_LOAD_HI = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_LOCK    = 6'h20;

    // control field positions
    localparam int CTRL_RUN_BIT  = 1;
    localparam int CTRL_MODE_BIT = 2;
    localparam int CTRL_RSTE_BIT = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PULSE = 2'd2,
        ST_HALT  = 2'd3
    } wdt_state_t;
endpackage

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int          DATA_W = 16,
    parameter logic [15:0] KEY    = 16'hE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              locked,
    output logic [DATA_W-1:0] load_lo,
    output logic [DATA_W-1:0] load_hi,
    output logic              ctrl_run,
    output logic              ctrl_mode,
    output logic              ctrl_rsten,
    output logic              run_start
);
    localparam int PAD_W = DATA_W - CTRL_RSTE_BIT - 1;

    logic wr_open;
    logic wr_lo, wr_hi, wr_ctrl, wr_lock;

    assign wr_open = bus_wr && !locked;
    assign wr_lo   = wr_open && (bus_addr == OFS_LOAD_LO);
    assign wr_hi   = wr_open && (bus_addr == OFS_LOAD_HI);
    assign wr_ctrl = wr_open && (bus_addr == OFS_CTRL);
    assign wr_lock = bus_wr  && (bus_addr == OFS_LOCK);

    // one-cycle strobe when run goes from clear to set
    assign run_start = wr_ctrl && bus_wdata[CTRL_RUN_BIT] && !ctrl_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked     <= 1'b1;
            load_lo    <= '0;
            load_hi    <= '0;
            ctrl_run   <= 1'b0;
            ctrl_mode  <= 1'b0;
            ctrl_rsten <= 1'b0;
        end else begin
            if (wr_lock) locked  <= (bus_wdata[15:0] != KEY);
            if (wr_lo)   load_lo <= bus_wdata;
            if (wr_hi)   load_hi <= bus_wdata;
            if (wr_ctrl) begin
                ctrl_run   <= bus_wdata[CTRL_RUN_BIT];
                ctrl_mode  <= bus_wdata[CTRL_MODE_BIT];
                ctrl_rsten <= bus_wdata[CTRL_RSTE_BIT];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_LOAD_LO: bus_rdata = load_lo;
            OFS_LOAD_HI: bus_rdata = load_hi;
            OFS_CTRL:    bus_rdata = {{PAD_W{1'b0}}, ctrl_rsten, ctrl_mode, ctrl_run, 1'b0};
            OFS_LOCK:    bus_rdata = {{(DATA_W-1){1'b0}}, locked};
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W        = 32,
    parameter int PULSE_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             rsten,
    input  logic             run_start,
    input  logic [CNT_W-1:0] load_val,
    output logic             wdt_reset
);
    localparam int             PW    = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [PW-1:0]  PLAST = PW'(PULSE_CYCLES - 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wdt_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [PW-1:0]    pcnt_q;
    logic             expire;

    assign expire = tick && (cnt_q <= ONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run_start) state_d = ST_COUNT;              // arm
            ST_COUNT: begin
                if (!run)        state_d = ST_IDLE;                    // abort
                else if (expire) state_d = rsten ? ST_PULSE : ST_HALT; // fire / expire_quiet
            end
            ST_PULSE: if (pcnt_q == PLAST) state_d = ST_HALT;         // pulse_done
            ST_HALT:  if (!run) state_d = ST_IDLE;                    // release
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath: down-counter and pulse length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pcnt_q <= '0;
        end else begin
            if (state_q == ST_IDLE && run_start)
                cnt_q <= load_val;
            else if (state_q == ST_COUNT && run && tick)
                cnt_q <= expire ? '0 : cnt_q - ONE;

            if (state_q == ST_PULSE) pcnt_q <= pcnt_q + 1'b1;
            else                     pcnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        wdt_reset = (state_q == ST_PULSE);
    end
endmodule

// File: rtl/keyed_wdt.sv
`timescale 1ns/1ps
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int          DATA_W       = 16,
    parameter logic [15:0] KEY          = 16'hE551,
    parameter int          PULSE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick,
    output logic              wdt_reset
);
    localparam int CNT_W = 2 * DATA_W;

    logic              locked;
    logic [DATA_W-1:0] load_lo, load_hi;
    logic              ctrl_run, ctrl_mode, ctrl_rsten;
    logic              run_start;

    wdt_regs #(.DATA_W(DATA_W), .KEY(KEY)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .locked     (locked),
        .load_lo    (load_lo),
        .load_hi    (load_hi),
        .ctrl_run   (ctrl_run),
        .ctrl_mode  (ctrl_mode),
        .ctrl_rsten (ctrl_rsten),
        .run_start  (run_start)
    );

    wdt_core #(.CNT_W(CNT_W), .PULSE_CYCLES(PULSE_CYCLES)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (ctrl_run),
        .rsten     (ctrl_rsten),
        .run_start (run_start),
        .load_val  ({load_hi, load_lo}),
        .wdt_reset (wdt_reset)
    );
endmodule

// File: rtl/keyed_wdt_chk.sv
`timescale 1ns/1ps
module keyed_wdt_chk
    import wdt_pkg::*;
#(
    parameter int          DATA_W       = 16,
    parameter logic [15:0] KEY          = 16'hE551,
    parameter int          PULSE_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              wdt_reset,
    input logic              locked,
    input logic [DATA_W-1:0] load_lo,
    input logic [DATA_W-1:0] load_hi,
    input logic              ctrl_run,
    input logic              ctrl_mode,
    input logic              ctrl_rsten
);
    localparam int LW = $clog2(PULSE_CYCLES + 1) + 1;

    logic [LW-1:0] high_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         high_len <= '0;
        else if (wdt_reset) high_len <= high_len + 1'b1;
        else                high_len <= '0;
    end

    // R2
    key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_LOCK && bus_wdata[15:0] == KEY) |=> !locked);

    // R2
    other_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_LOCK && bus_wdata[15:0] != KEY) |=> locked);

    // R3
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bus_wr && bus_addr != OFS_LOCK) |=>
        ($stable(load_lo) && $stable(load_hi) && $stable(ctrl_run) &&
         $stable(ctrl_mode) && $stable(ctrl_rsten)));

    // R7
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |-> (high_len < PULSE_CYCLES));

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_reset) |-> (high_len == PULSE_CYCLES));

    // R9
    pulse_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_reset) |-> $past(ctrl_rsten));
endmodule

bind keyed_wdt keyed_wdt_chk #(
    .DATA_W(DATA_W), .KEY(KEY), .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (.*);

// File: tb/sim_keyed_wdt.sv
`timescale 1ns/1ps
module sim_keyed_wdt;
    localparam logic [5:0]  A_LO   = 6'h00;
    localparam logic [5:0]  A_HI   = 6'h04;
    localparam logic [5:0]  A_CTRL = 6'h08;
    localparam logic [5:0]  A_LOCK = 6'h20;
    localparam logic [15:0] KEY    = 16'hE551;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        tick = 1'b0;
    logic [15:0] bus_rdata;
    logic        wdt_reset;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    keyed_wdt u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick      (tick),
        .wdt_reset (wdt_reset)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [15:0] exp, input string req);
        bus_addr = a;
        #1;
        chk(bus_rdata == exp, req, int'(bus_rdata), int'(exp));
    endtask

    task automatic one_tick;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic measure_pulse(output int n);
        n = 0;
        for (int i = 0; i < 16; i++) begin
            if (wdt_reset) n++;
            @(negedge clk);
        end
    endtask

    task automatic arm(input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] ctrl);
        wr(A_LOCK, KEY);
        wr(A_CTRL, 16'h0);
        wr(A_HI, hi);
        wr(A_LO, lo);
        wr(A_CTRL, ctrl);
        wr(A_LOCK, ~KEY);
    endtask

    task automatic t_reset_state;
        rd_chk(A_LOCK, 16'h1, "R1 lock");
        rd_chk(A_LO,   16'h0, "R1 lo");
        rd_chk(A_HI,   16'h0, "R1 hi");
        rd_chk(A_CTRL, 16'h0, "R1 ctrl");
        chk(wdt_reset == 1'b0, "R1 reset out", int'(wdt_reset), 0);
    endtask

    task automatic t_lock_and_regs;
        wr(A_LO, 16'h1234);
        rd_chk(A_LO, 16'h0, "R3 locked lo");
        wr(A_LOCK, 16'hE550);
        rd_chk(A_LOCK, 16'h1, "R2 wrong key");
        wr(A_LOCK, KEY);
        rd_chk(A_LOCK, 16'h0, "R2 key opens");
        wr(A_LO, 16'h00AB);
        wr(A_HI, 16'h0001);
        rd_chk(A_LO, 16'h00AB, "R4 lo");
        rd_chk(A_HI, 16'h0001, "R4 hi");
        wr(A_CTRL, 16'hFFF5);
        rd_chk(A_CTRL, 16'h0004, "R5 mode only");
        wr(A_CTRL, 16'h0000);
        wr(A_LOCK, ~KEY);
        rd_chk(A_LOCK, 16'h1, "R2 relock");
        wr(A_HI, 16'h5555);
        rd_chk(A_HI, 16'h0001, "R3 locked hi");
        wr(A_CTRL, 16'h000A);
        rd_chk(A_CTRL, 16'h0000, "R3 locked ctrl");
        for (int i = 0; i < 4; i++) begin
            one_tick();
            chk(wdt_reset == 1'b0, "R3 no run while locked", int'(wdt_reset), 0);
        end
    endtask

    task automatic t_expire_and_halt;
        int n;
        arm(16'd3, 16'd0, 16'h000E);
        rd_chk(A_CTRL, 16'h000E, "R5 ctrl fields");
        one_tick(); one_tick();
        chk(wdt_reset == 1'b0, "R6 before third tick", int'(wdt_reset), 0);
        one_tick();
        chk(wdt_reset == 1'b1, "R6 third tick expires", int'(wdt_reset), 1);
        measure_pulse(n);
        chk(n == 8, "R7 pulse width", n, 8);
        for (int i = 0; i < 3; i++) begin
            one_tick();
            chk(wdt_reset == 1'b0, "R8 halted", int'(wdt_reset), 0);
        end
        arm(16'd2, 16'd0, 16'h000A);
        one_tick();
        chk(wdt_reset == 1'b0, "R5 no mode, tick one", int'(wdt_reset), 0);
        one_tick();
        chk(wdt_reset == 1'b1, "R8 rearmed expiry", int'(wdt_reset), 1);
        measure_pulse(n);
        chk(n == 8, "R7 pulse width again", n, 8);
    endtask

    task automatic t_zero_load;
        int n;
        arm(16'd0, 16'd0, 16'h000A);
        chk(wdt_reset == 1'b0, "R6 zero load idle", int'(wdt_reset), 0);
        one_tick();
        chk(wdt_reset == 1'b1, "R6 zero load first tick", int'(wdt_reset), 1);
        measure_pulse(n);
        chk(n == 8, "R7 zero load pulse", n, 8);
    endtask

    task automatic t_no_enable;
        arm(16'd2, 16'd0, 16'h0002);
        for (int i = 0; i < 5; i++) begin
            one_tick();
            chk(wdt_reset == 1'b0, "R9 no reset enable", int'(wdt_reset), 0);
        end
    endtask

    task automatic t_abort;
        arm(16'd3, 16'd0, 16'h000A);
        one_tick(); one_tick();
        wr(A_LOCK, KEY);
        wr(A_CTRL, 16'h0008);
        wr(A_LOCK, ~KEY);
        for (int i = 0; i < 5; i++) begin
            one_tick();
            chk(wdt_reset == 1'b0, "R10 run cleared", int'(wdt_reset), 0);
        end
    endtask

    task automatic t_high_half;
        int n;
        arm(16'd0, 16'd1, 16'h000A);
        @(negedge clk); tick = 1'b1;
        repeat (65535) @(negedge clk);
        chk(wdt_reset == 1'b0, "R4 high half tick 65535", int'(wdt_reset), 0);
        @(negedge clk);
        tick = 1'b0;
        chk(wdt_reset == 1'b1, "R4 high half tick 65536", int'(wdt_reset), 1);
        measure_pulse(n);
        chk(n == 8, "R7 long timeout pulse", n, 8);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_lock_and_regs();
        t_expire_and_halt();
        t_zero_load();
        t_no_enable();
        t_abort();
        t_high_half();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule